// File: doc/BRIEF.md
# Graphic LCD Display Memory Host Port

This block is the host side of a small graphic LCD controller. It holds a display memory of 4 pages by 80 columns of bytes, and a parallel host bus reaches it. The bus can be wired as a 6800-style bus (one read/write line plus an enable) or as an 8080-style bus (separate active-low read and write strobes). A register-select line `a0` chooses between data and control. With `a0` high, a host access reads or writes display memory at the current page and column, and the column then steps forward. With `a0` low, a write is a command and a read returns the status byte.

Display data reads pass through a one-byte holding register. Each read returns what the holder already contained and then refills it from memory. After the column is moved, or after a write, the first read is therefore a dummy read. Writes reach memory in the cycle they are taken, and they also load the holder. A command makes the block busy for a short time. While it is busy, only status reads have any effect.

A second port serves display refresh. A line address selects one pixel row: the page is the line divided by 8, and the bit within each byte is the line modulo 8. On each refresh clock edge the port latches that bit from each of the 61 segment-driving columns. The remaining columns, 61 to 79, are plain storage that the host can read and write.

Top module: `lcd_ram_port`

## Requirements
- R1: Access decode on the host clock. When `bus_i80`=1, a read is `rd_n`=0 with `wr_n`=1, and a write is `wr_n`=0 with `rd_n`=1. When `bus_i80`=0, a read is `en`=1 with `rw_n`=1, and a write is `en`=1 with `rw_n`=0. The strobes of the bus style that is not selected have no effect. `a0`=1 selects display data and `a0`=0 selects command or status.
- R2: A data write stores `din` at byte index page*80+column in the same clock cycle. Columns 61 to 79 store and return data like every other column.
- R3: A data read drives `dout` with the previous holder contents, one cycle after the access. It then loads the holder from the current byte. A data write loads the holder with the written byte.
- R4: The column advances by one after each accepted data read or write, and it stays at 79 once there.
- R5: The command `0ccccccc` sets the column to c, limited to 79. The command `100000pp` sets the page to pp.
- R6: The command `1010000d` sets ADC direction to d (1 = forward). The command `1010010m` sets display mode to m (1 = all lit).
- R7: A status read returns {busy, adc, mode, resetting, 4'b0000} on `dout` one cycle after the access.
- R8: An accepted command other than reset makes the block busy for the next 2 clock cycles. While busy, data accesses and commands change nothing.
- R9: Command 8'hE2 sets busy and resetting for 4 cycles, sets ADC to forward and sets display mode to normal.
- R10: On each `disp_clk` edge, `seg_row[c]` gets bit (line mod 8) of byte (line/8)*80+c, for c = 0 to 60.
- R11: If a host write and a refresh read hit the same byte on the same edge, the refresh port returns the old byte.
- R12: After `rst_n` the block is in this state: column 0, page 0, ADC forward, display mode normal, not busy, not resetting, and `dout` and the holder both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i80 | input | 1 | 1 = 8080-style strobes, 0 = 6800-style strobes |
| a0 | input | 1 | 1 = display data, 0 = command/status |
| rw_n | input | 1 | 6800 read (1) / write (0) |
| en | input | 1 | 6800 enable |
| rd_n | input | 1 | 8080 read strobe, active low |
| wr_n | input | 1 | 8080 write strobe, active low |
| din | input | 8 | Write data or command byte |
| dout | output | 8 | Read data or status byte |
| disp_clk | input | 1 | Refresh clock |
| line | input | 5 | Refresh line address |
| seg_row | output | 61 | Latched pixel row for the segment columns |

## Verification
The assertions check on every cycle the rules that hold independently of memory contents:
- the column stays in range and steps or saturates as required;
- the holder takes the written byte;
- busy follows each accepted command, and ignored accesses leave the column unchanged;
- the reset command sets its flags, and resetting always implies busy;
- the unused low bits of status are zero and its busy bit matches.

Only the bench scenarios can show the data behaviour. These are the stored byte contents across every page and column, the lag of one read caused by the holder, column limiting, the rejected strobes of the unselected bus style, the refresh row for every line, and the old-data result of a refresh that collides with a write.

// File: rtl/lcd_ram_port.sv
module lcd_ram_port #(
  parameter int PAGES    = 4,
  parameter int COLS     = 80,
  parameter int SEGS     = 61,
  parameter int BUSY_CMD = 2,
  parameter int BUSY_RST = 4,
  parameter int LINE_W   = $clog2(PAGES * 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_i80,
  input  logic              a0,
  input  logic              rw_n,
  input  logic              en,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  input  logic              disp_clk,
  input  logic [LINE_W-1:0] line,
  output logic [SEGS-1:0]   seg_row
);
  localparam int PW    = (PAGES > 1) ? $clog2(PAGES) : 1;
  localparam int CW    = $clog2(COLS);
  localparam int DEPTH = PAGES * COLS;
  localparam int AW    = $clog2(DEPTH);
  localparam int BW    = $clog2(BUSY_RST + 1);
  localparam logic [7:0] CMD_RESET = 8'hE2;

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] col;
  logic [PW-1:0] page;
  logic [7:0]    holder;
  logic [BW-1:0] bcnt;
  logic          adc, allon, rst_flag;

  logic rd_strb, wr_strb, busy, st_rd, dt_rd, dt_wr, cm_wr;
  logic [AW-1:0] addr;

  assign rd_strb = bus_i80 ? (!rd_n && wr_n) : (en && rw_n);
  assign wr_strb = bus_i80 ? (!wr_n && rd_n) : (en && !rw_n);
  assign busy    = (bcnt != '0);
  assign st_rd   = rd_strb && !a0;
  assign dt_rd   = rd_strb && a0 && !busy;
  assign dt_wr   = wr_strb && a0 && !busy;
  assign cm_wr   = wr_strb && !a0 && !busy;
  assign addr    = AW'(page) * AW'(COLS) + AW'(col);

  always_ff @(posedge clk) begin
    if (dt_wr) mem[addr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col      <= '0;
      page     <= '0;
      holder   <= '0;
      dout     <= '0;
      bcnt     <= '0;
      adc      <= 1'b1;
      allon    <= 1'b0;
      rst_flag <= 1'b0;
    end else begin
      if (busy) bcnt <= bcnt - 1'b1;
      if (bcnt == BW'(1)) rst_flag <= 1'b0;

      if (st_rd) dout <= {busy, adc, allon, rst_flag, 4'b0000};
      else if (dt_rd) dout <= holder;

      if (dt_rd) holder <= mem[addr];
      else if (dt_wr) holder <= din;

      if ((dt_rd || dt_wr) && col != CW'(COLS - 1)) col <= col + 1'b1;

      if (cm_wr) begin
        bcnt <= BW'(BUSY_CMD);
        if (!din[7]) begin
          col <= (int'(din[6:0]) > COLS - 1) ? CW'(COLS - 1) : CW'(din[6:0]);
        end else if (din[7:2] == 6'b100000) begin
          page <= PW'(din[1:0]);
        end else if (din[7:1] == 7'b1010000) begin
          adc <= din[0];
        end else if (din[7:1] == 7'b1010010) begin
          allon <= din[0];
        end else if (din == CMD_RESET) begin
          bcnt     <= BW'(BUSY_RST);
          rst_flag <= 1'b1;
          adc      <= 1'b1;
          allon    <= 1'b0;
        end
      end
    end
  end

  logic [PW-1:0] lpage;
  logic [2:0]    lbit;
  assign lpage = PW'(line[LINE_W-1:3]);
  assign lbit  = line[2:0];

  always_ff @(posedge disp_clk) begin
    for (int c = 0; c < SEGS; c++) begin
      seg_row[c] <= mem[AW'(lpage) * AW'(COLS) + AW'(c)][lbit];
    end
  end
endmodule

module lcd_ram_port_chk #(
  parameter int COLS = 80
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     a0,
  input logic [7:0]               din,
  input logic [7:0]               dout,
  input logic [$clog2(COLS)-1:0]  col,
  input logic [7:0]               holder,
  input logic                     rd_strb,
  input logic                     wr_strb,
  input logic                     busy,
  input logic                     adc,
  input logic                     allon,
  input logic                     rst_flag
);
  p_col_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col) <= COLS - 1);

  p_col_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_strb || wr_strb) && a0 && !busy && int'(col) != COLS - 1)
      |=> (col == $past(col) + 1'b1));

  p_write_holder_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strb && a0 && !busy) |=> (holder == $past(din)));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && a0 && (rd_strb || wr_strb)) |=> $stable(col));

  p_cmd_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strb && !a0 && !busy) |=> busy);

  p_reset_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strb && !a0 && !busy && din == 8'hE2) |=> (rst_flag && busy && adc && !allon));

  p_reset_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_flag |-> busy);

  p_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strb && !a0) |=> (dout[3:0] == 4'b0000 && dout[7] == $past(busy)));
endmodule

bind lcd_ram_port lcd_ram_port_chk #(.COLS(COLS)) u_chk (.*);

// File: tb/tb_lcd_ram_port.sv
module tb_lcd_ram_port;
  logic clk = 0, rst_n = 0;
  logic bus_i80 = 0, a0 = 0, rw_n = 1, en = 0, rd_n = 1, wr_n = 1;
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic [4:0] line = 0;
  logic [60:0] seg_row;
  logic disp_clk;

  always #4 clk = ~clk;
  assign disp_clk = clk;

  lcd_ram_port dut (
    .clk(clk), .rst_n(rst_n), .bus_i80(bus_i80), .a0(a0), .rw_n(rw_n), .en(en),
    .rd_n(rd_n), .wr_n(wr_n), .din(din), .dout(dout),
    .disp_clk(disp_clk), .line(line), .seg_row(seg_row)
  );

  int checks = 0, fails = 0;
  logic [7:0] mm [320];
  int col_m = 0, pg_m = 0;
  logic [7:0] hold_m = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    en = 0; rd_n = 1; wr_n = 1; rw_n = 1;
  endtask

  task automatic acc(bit m80, bit a, bit rd, logic [7:0] d);
    @(negedge clk);
    bus_i80 = m80; a0 = a; din = d;
    if (m80) begin en = 0; rw_n = 1; rd_n = !rd; wr_n = rd; end
    else begin rd_n = 1; wr_n = 1; en = 1; rw_n = rd; end
    @(negedge clk);
    idle();
  endtask

  function automatic int nxt(int c);
    return (c < 79) ? c + 1 : 79;
  endfunction

  task automatic cmd(bit m80, logic [7:0] c);
    acc(m80, 0, 0, c);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_col(int c);
    cmd(0, 8'(c));
    col_m = (c > 79) ? 79 : c;
  endtask

  task automatic set_pg(int p);
    cmd(1, 8'h80 | 8'(p));
    pg_m = p;
  endtask

  task automatic dwr(bit m80, logic [7:0] d);
    acc(m80, 1, 0, d);
    mm[pg_m * 80 + col_m] = d;
    hold_m = d;
    col_m = nxt(col_m);
  endtask

  task automatic drd(bit m80, string req);
    acc(m80, 1, 1, 8'h00);
    chk(req, dout, hold_m);
    hold_m = mm[pg_m * 80 + col_m];
    col_m = nxt(col_m);
  endtask

  task automatic st(bit m80, logic [7:0] exp, string req);
    acc(m80, 0, 1, 8'h00);
    chk(req, dout, exp);
  endtask

  function automatic logic [60:0] row_exp(int ln);
    logic [60:0] r;
    for (int c = 0; c < 61; c++) r[c] = mm[(ln / 8) * 80 + c][ln % 8];
    return r;
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R12 dout after reset", dout, 8'h00);
    st(0, 8'h40, "R12 R7 reset status");
    drd(1, "R12 holder zero after reset");

    for (int p = 0; p < 4; p++) begin
      set_pg(p);
      set_col(0);
      for (int c = 0; c < 80; c++) dwr(c[0], 8'((p * 37 + c * 11) ^ 8'hA5));
      dwr(p[0], 8'h3C ^ 8'(p));
    end

    for (int p = 0; p < 4; p++) begin
      set_pg(p);
      set_col(0);
      drd(p[0], "R3 dummy read after address set");
      for (int c = 0; c < 81; c++) drd(c[1], "R2 R3 R4 readback");
    end

    set_pg(2);
    set_col(120);
    dwr(0, 8'h99);
    set_col(79);
    drd(1, "R5 dummy after clamp");
    drd(1, "R5 column limited to 79");
    set_col(10);
    dwr(1, 8'h5E);
    drd(0, "R3 read after write returns written byte");

    set_pg(1);
    @(negedge clk);
    bus_i80 = 0; a0 = 1; din = 8'hFF; en = 0; rw_n = 0; wr_n = 0; rd_n = 1;
    @(negedge clk);
    bus_i80 = 1; en = 1; rw_n = 0; wr_n = 1; rd_n = 1;
    @(negedge clk);
    idle();
    set_col(20);
    drd(1, "R1 dummy");
    drd(0, "R1 unselected strobes ignored");

    for (int l = 0; l < 32; l++) begin
      @(negedge clk);
      line = 5'(l);
      @(negedge clk);
      chk("R10 refresh row", 64'(seg_row), 64'(row_exp(l)));
    end

    set_pg(3);
    set_col(30);
    line = 5'd29;
    @(negedge clk);
    acc(1, 1, 0, 8'(~mm[3 * 80 + 30]));
    chk("R11 collision returns old row", 64'(seg_row), 64'(row_exp(29)));
    mm[3 * 80 + 30] = ~mm[3 * 80 + 30];
    hold_m = mm[3 * 80 + 30];
    col_m = 31;
    @(negedge clk);
    chk("R11 new row next edge", 64'(seg_row), 64'(row_exp(29)));

    cmd(0, 8'hA0);
    cmd(1, 8'hA5);
    st(0, 8'h20, "R6 R7 adc reverse, all lit");

    acc(0, 0, 0, 8'hE2);
    st(1, 8'hD0, "R9 resetting status");
    acc(0, 1, 0, 8'h77);
    st(0, 8'h40, "R9 flags cleared after 4 cycles");
    set_col(31);
    drd(1, "R8 dummy");
    drd(1, "R8 write during busy ignored");

    acc(1, 0, 0, 8'h05);
    st(1, 8'hC0, "R8 busy after command");
    st(0, 8'h40, "R8 busy over after 2 cycles");
    col_m = 5;
    drd(0, "R8 dummy after busy");
    drd(0, "R8 column from command");

    finish_up();
  end
endmodule